// File: doc/BRIEF.md
# Machine Timer and Software-Interrupt Window

This block holds the timer state for a single hart. It has a free-running 64-bit time counter, a 64-bit compare value and a one-bit software-interrupt flag. It produces two level outputs for the core's interrupt logic: a timer-pending line and a software-pending line.

The same three registers can be reached through two address maps on one 32-bit MMIO port. The first is a compact native map at the bottom of the block's range. The second is a window laid out the way the common core-local interruptor layout expects, so that a stock operating-system timer driver can program it. The second window adds no storage. Every address in both maps decodes onto the same flops, so a value written through one map can be read back through the other.

Each 64-bit register is split into a low word at +0 and a high word at +4. A timer interrupt that is armed entirely through the second window raises the timer-pending line, and the core then reports it as machine timer interrupt cause 0x8000_0007.

Top module: `mtimer_window`

## Requirements
- R1: The time counter advances by exactly 1 on every clock in which no time word is written, and carries from the low word into the high word.
- R2: A write to a time word replaces that 32-bit half with the write data and leaves the other half as it was. In that cycle the counter does not advance.
- R3: Reset sets the time counter to 0, the compare value to all-ones and the software flag to 0. Both interrupt lines are then low.
- R4: The timer-pending output is high exactly when the time counter is greater than or equal to the compare value, using an unsigned 64-bit compare.
- R5: Compatible window, with base 0x10000: the software flag is at base+0x0. The compare value is at base+0x4000 (low) and base+0x4004 (high). The time counter is at base+0xBFF8 (low) and base+0xBFFC (high).
- R6: Native map: time low at 0x00, time high at 0x04, compare low at 0x08, compare high at 0x0C, software flag at 0x10.
- R7: Both maps alias the same state. A write through either map is visible on a read through the other.
- R8: Only bit 0 of the software-flag word is stored. It drives the software-pending output directly, and bits 31:1 read as zero.
- R9: Reads of an address that is not mapped return 0. Writes to such an address change no state.
- R10: Writing the compare value to a value above the current time drops the timer-pending output at the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 17 | Byte address within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the read |
| mtip | output | 1 | Machine timer interrupt pending |
| msip | output | 1 | Machine software interrupt pending |

## Verification
The bench writes and reads the same registers through alternate maps. A decoder that gave the second window its own storage would then return stale values. It drives the counter through the low-to-high carry, which catches a counter that was split into two unlinked words. It also checks that the counter holds still across a word write, so a design that increments during the write reads back one too high. The bench walks the time counter up to the compare value and checks the pending line in the cycle before equality and in the cycle of equality, which exposes a strict greater-than compare or a signed compare. Finally, it rewrites the compare value above the time counter and checks that the pending line drops right after that edge, and it confirms that unmapped addresses and the spare bits of the software flag read as zero.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

  typedef enum logic [2:0] {
    SelNone,
    SelTime0,
    SelTime1,
    SelCmp0,
    SelCmp1,
    SelSip
  } rdSel_e;

  // strobes from decode to the register datapath; index 0 = low word
  typedef struct packed {
    logic [1:0] wrTime;
    logic [1:0] wrCmp;
    logic       wrSip;
    rdSel_e     rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/mtw_ctrl.sv
module mtw_ctrl
  import mtw_pkg::*;
#(
  parameter int                   AddrWidth  = 17,
  parameter logic [AddrWidth-1:0] NativeBase = '0,
  parameter logic [AddrWidth-1:0] ClintBase  = AddrWidth'('h10000)
) (
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [AddrWidth-1:0] busAddr,
  output ctrlStrobes_t         strobes
);

  localparam logic [AddrWidth-1:0] NatTime0 = NativeBase + AddrWidth'('h00);
  localparam logic [AddrWidth-1:0] NatTime1 = NativeBase + AddrWidth'('h04);
  localparam logic [AddrWidth-1:0] NatCmp0  = NativeBase + AddrWidth'('h08);
  localparam logic [AddrWidth-1:0] NatCmp1  = NativeBase + AddrWidth'('h0C);
  localparam logic [AddrWidth-1:0] NatSip   = NativeBase + AddrWidth'('h10);

  localparam logic [AddrWidth-1:0] WinSip   = ClintBase;
  localparam logic [AddrWidth-1:0] WinCmp0  = ClintBase + AddrWidth'('h4000);
  localparam logic [AddrWidth-1:0] WinCmp1  = ClintBase + AddrWidth'('h4004);
  localparam logic [AddrWidth-1:0] WinTime0 = ClintBase + AddrWidth'('hBFF8);
  localparam logic [AddrWidth-1:0] WinTime1 = ClintBase + AddrWidth'('hBFFC);

  rdSel_e hitSel;
  logic   doWrite;

  always_comb begin
    hitSel = SelNone;
    if (busAddr == NatTime0 || busAddr == WinTime0)      hitSel = SelTime0;
    else if (busAddr == NatTime1 || busAddr == WinTime1) hitSel = SelTime1;
    else if (busAddr == NatCmp0 || busAddr == WinCmp0)   hitSel = SelCmp0;
    else if (busAddr == NatCmp1 || busAddr == WinCmp1)   hitSel = SelCmp1;
    else if (busAddr == NatSip || busAddr == WinSip)     hitSel = SelSip;
  end

  assign doWrite = busValid && busWrite;

  always_comb begin
    strobes.wrTime[0] = doWrite && (hitSel == SelTime0);
    strobes.wrTime[1] = doWrite && (hitSel == SelTime1);
    strobes.wrCmp[0]  = doWrite && (hitSel == SelCmp0);
    strobes.wrCmp[1]  = doWrite && (hitSel == SelCmp1);
    strobes.wrSip     = doWrite && (hitSel == SelSip);
    strobes.rdSel     = (busValid && !busWrite) ? hitSel : SelNone;
  end

endmodule

// File: rtl/mtw_dp.sv
module mtw_dp
  import mtw_pkg::*;
#(
  parameter int WordWidth = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrlStrobes_t           strobes,
  input  logic [WordWidth-1:0]   wdata,
  output logic [WordWidth-1:0]   rdata,
  output logic [2*WordWidth-1:0] timeVal,
  output logic [2*WordWidth-1:0] cmpVal,
  output logic                   mtip,
  output logic                   msip
);

  localparam int Halves    = 2;
  localparam int TimeWidth = Halves * WordWidth;

  logic [TimeWidth-1:0] timeQ;
  logic [TimeWidth-1:0] cmpQ;
  logic                 sipQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      timeQ <= '0;
    end else if (|strobes.wrTime) begin
      if (strobes.wrTime[0]) timeQ[WordWidth-1:0]         <= wdata;
      if (strobes.wrTime[1]) timeQ[TimeWidth-1:WordWidth] <= wdata;
    end else begin
      timeQ <= timeQ + TimeWidth'(1);
    end
  end

  for (genvar h = 0; h < Halves; h++) begin : g_cmpWord
    logic [WordWidth-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (rst)                 wordQ <= '1;
      else if (strobes.wrCmp[h]) wordQ <= wdata;
    end
    assign cmpQ[h*WordWidth +: WordWidth] = wordQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                sipQ <= 1'b0;
    else if (strobes.wrSip) sipQ <= wdata[0];
  end

  always_comb begin
    case (strobes.rdSel)
      SelTime0: rdata = timeQ[WordWidth-1:0];
      SelTime1: rdata = timeQ[TimeWidth-1:WordWidth];
      SelCmp0:  rdata = cmpQ[WordWidth-1:0];
      SelCmp1:  rdata = cmpQ[TimeWidth-1:WordWidth];
      SelSip:   rdata = {{(WordWidth-1){1'b0}}, sipQ};
      default:  rdata = '0;
    endcase
  end

  assign mtip    = (timeQ >= cmpQ);
  assign msip    = sipQ;
  assign timeVal = timeQ;
  assign cmpVal  = cmpQ;

endmodule

// File: rtl/mtimer_window.sv
module mtimer_window
  import mtw_pkg::*;
#(
  parameter int                   AddrWidth  = 17,
  parameter int                   WordWidth  = 32,
  parameter logic [AddrWidth-1:0] NativeBase = '0,
  parameter logic [AddrWidth-1:0] ClintBase  = AddrWidth'('h10000)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [AddrWidth-1:0] busAddr,
  input  logic [WordWidth-1:0] busWdata,
  output logic [WordWidth-1:0] busRdata,
  output logic                 mtip,
  output logic                 msip
);

  ctrlStrobes_t           strobes;
  logic [2*WordWidth-1:0] timeVal;
  logic [2*WordWidth-1:0] cmpVal;

  mtw_ctrl #(
    .AddrWidth (AddrWidth),
    .NativeBase(NativeBase),
    .ClintBase (ClintBase)
  ) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  mtw_dp #(
    .WordWidth(WordWidth)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .timeVal(timeVal),
    .cmpVal (cmpVal),
    .mtip   (mtip),
    .msip   (msip)
  );

endmodule

// File: rtl/mtimer_window_chk.sv
module mtimer_window_chk #(
  parameter int                   AddrWidth  = 17,
  parameter int                   WordWidth  = 32,
  parameter logic [AddrWidth-1:0] NativeBase = '0,
  parameter logic [AddrWidth-1:0] ClintBase  = AddrWidth'('h10000)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   busValid,
  input logic                   busWrite,
  input logic [AddrWidth-1:0]   busAddr,
  input logic                   wbit0,
  input logic                   mtip,
  input logic                   msip,
  input logic [2*WordWidth-1:0] timeVal,
  input logic [2*WordWidth-1:0] cmpVal
);

  logic wr;
  logic timeWrite;
  logic cmpWrite;
  logic sipWrite;

  assign wr = busValid && busWrite;
  assign timeWrite = wr && (busAddr == NativeBase || busAddr == NativeBase + AddrWidth'('h4) ||
                            busAddr == ClintBase + AddrWidth'('hBFF8) ||
                            busAddr == ClintBase + AddrWidth'('hBFFC));
  assign cmpWrite  = wr && (busAddr == NativeBase + AddrWidth'('h8) ||
                            busAddr == NativeBase + AddrWidth'('hC) ||
                            busAddr == ClintBase + AddrWidth'('h4000) ||
                            busAddr == ClintBase + AddrWidth'('h4004));
  assign sipWrite  = wr && (busAddr == NativeBase + AddrWidth'('h10) || busAddr == ClintBase);

  AST_TIME_TICK: assert property (@(posedge clk) disable iff (rst)
    !timeWrite |=> timeVal == $past(timeVal) + 64'd1); // R1

  AST_MTIP_RISE_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!timeWrite && !cmpWrite) |=> (!$rose(mtip) || timeVal == cmpVal)); // R4

  AST_MTIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mtip && !timeWrite && !cmpWrite) |=> mtip); // R4

  AST_SIP_LOAD: assert property (@(posedge clk) disable iff (rst)
    sipWrite |=> msip == $past(wbit0)); // R8

  AST_SIP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !sipWrite |=> $stable(msip)); // R8

endmodule

bind mtimer_window mtimer_window_chk #(
  .AddrWidth (AddrWidth),
  .WordWidth (WordWidth),
  .NativeBase(NativeBase),
  .ClintBase (ClintBase)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .wbit0   (busWdata[0]),
  .mtip    (mtip),
  .msip    (msip),
  .timeVal (timeVal),
  .cmpVal  (cmpVal)
);

// File: tb/mtimer_window_tb.sv
module mtimer_window_tb;

  localparam int ClkPeriod = 10;

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        expSip;
  } vec_t;

  // R7 aliasing, R8 flag bits, R9 unmapped
  localparam vec_t Vecs [12] = '{
    '{1'b1, 17'h10000, 32'hFFFF_FFFF, 32'h0,         1'b1},
    '{1'b0, 17'h00010, 32'h0,         32'h1,         1'b1},
    '{1'b0, 17'h10000, 32'h0,         32'h1,         1'b1},
    '{1'b1, 17'h00010, 32'h0000_0002, 32'h0,         1'b0},
    '{1'b0, 17'h10000, 32'h0,         32'h0,         1'b0},
    '{1'b1, 17'h14004, 32'h1234_5678, 32'h0,         1'b0},
    '{1'b0, 17'h0000C, 32'h0,         32'h1234_5678, 1'b0},
    '{1'b1, 17'h00008, 32'hCAFE_F00D, 32'h0,         1'b0},
    '{1'b0, 17'h14000, 32'h0,         32'hCAFE_F00D, 1'b0},
    '{1'b0, 17'h00020, 32'h0,         32'h0,         1'b0},
    '{1'b1, 17'h14008, 32'h0,         32'h0,         1'b0},
    '{1'b0, 17'h14004, 32'h0,         32'h1234_5678, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [16:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mtip;
  logic        msip;

  int checks = 0;
  int fails  = 0;

  always #(ClkPeriod/2) clk = ~clk;

  mtimer_window u_dut (
    .clk     (clk),
    .rst     (rst),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .mtip    (mtip),
    .msip    (msip)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic busWr(input logic [16:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  // combinational read, consumes no clock edge
  task automatic busRd(input logic [16:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busValid = 1'b0;
  endtask

  initial begin
    #(ClkPeriod * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    busRd(17'h00000, rd); check("R3 time low", rd, 32'h0);
    busRd(17'h00008, rd); check("R3 cmp low", rd, 32'hFFFF_FFFF);
    busRd(17'h1400C - 17'h8, rd); check("R3 cmp high", rd, 32'hFFFF_FFFF);
    busRd(17'h00010, rd); check("R3 flag", rd, 32'h0);
    check("R3 mtip", {31'b0, mtip}, 32'h0);
    check("R3 msip", {31'b0, msip}, 32'h0);
    repeat (3) @(negedge clk);
    busRd(17'h00000, rd); check("R1 count after 3 clocks", rd, 32'h3);

    for (int i = 0; i < 12; i++) begin
      if (Vecs[i].wr) begin
        busWr(Vecs[i].addr, Vecs[i].data);
      end else begin
        busRd(Vecs[i].addr, rd);
        check("R7/R8/R9 read", rd, Vecs[i].exp);
      end
      check("R8 msip output", {31'b0, msip}, {31'b0, Vecs[i].expSip});
    end

    // R2 write holds the counter; R5 window time address; R1 carry
    busWr(17'h1BFF8, 32'hFFFF_FFFE);
    busWr(17'h1BFFC, 32'h0);
    busRd(17'h00000, rd); check("R2 time low after write", rd, 32'hFFFF_FFFE);
    busRd(17'h00004, rd); check("R2 time high after write", rd, 32'h0);
    repeat (2) @(negedge clk);
    busRd(17'h00004, rd); check("R1 carry high", rd, 32'h1);
    busRd(17'h1BFF8, rd); check("R1 carry low", rd, 32'h0);

    // R4 arm through the compatible window, R6 native time
    busWr(17'h1BFF8, 32'd1000);
    busWr(17'h1BFFC, 32'h0);
    busWr(17'h14004, 32'h0);
    busWr(17'h14000, 32'd1010);
    busRd(17'h00000, rd); check("R6 native time low", rd, 32'd1002);
    check("R4 mtip below compare", {31'b0, mtip}, 32'h0);
    repeat (7) @(negedge clk);
    check("R4 mtip one below", {31'b0, mtip}, 32'h0);
    @(negedge clk);
    check("R4 mtip at equality", {31'b0, mtip}, 32'h1);

    // R10 compare moved above time
    busWr(17'h00008, 32'd5000);
    check("R10 mtip drops", {31'b0, mtip}, 32'h0);
    busRd(17'h1BFF8, rd); check("R10 time low", rd, 32'd1011);

    // R4 time written past compare
    busWr(17'h00000, 32'd6000);
    check("R4 mtip after time jump", {31'b0, mtip}, 32'h1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule